// File: doc/BRIEF.md
# Sector Write Command Sequencer

This block runs one sector write against a command-driven disk controller through a byte-wide mailbox. A single start pulse latches a track number, a zero-based sector number, a size code and a memory base address. The sequencer then issues, in fixed order, the track-select command and its argument, the sector-select command and its argument, a seek command and a write command. After each of these four steps it waits for an acknowledge byte from the controller.

Once the write command is acknowledged, the sequencer streams the sector payload. It reads the payload from a memory read port and sends one byte per mailbox write. It gates every byte on two controller status bits and applies a poll timeout to each byte. After the last byte it waits for one final acknowledge. It reports the outcome on a done flag, or on an error flag together with an error code. The flag stays set until the next start.

Top module: `sec_wr_seq`

## Requirements
- R1: With default parameters the mailbox bytes are, in order: 8'h21, track, 8'h22, sector argument, 8'h23, 8'h24, then the payload. An acknowledge is awaited after the track byte, after the sector argument, after 8'h23 and after 8'h24, and no further byte is sent until that acknowledge arrives.
- R2: The sector argument equals `sector_i + 1` modulo 256, so an input of 255 is sent as 8'h00.
- R3: The payload length is 128 << `size_i`, giving 128, 256, 512 or 1024 bytes for codes 0..3. Payload byte j is the value `mem_data_i` returns for address `base_addr_i + j`.
- R4: `mb_wr_o` is high only in a cycle in which `rx_dir_i` and `taken_i` are both high. A byte held back by either signal is sent later, unchanged.
- R5: Each cycle that a payload byte waits with `rx_dir_i & taken_i` low counts as one failed poll. After 254 failed polls the byte is still sent. On the 255th failed poll the operation ends with `err_o` set and `err_code_o` = 8'hE1, and no further byte is sent.
- R6: An acknowledge code of 8'h00 means success. Any other code, at any of the five acknowledge points, ends the operation at once: `err_o` is set, `err_code_o` equals the received code, and no further mailbox byte is sent.
- R7: When the final acknowledge after the payload is 8'h00, `done_o` is set with `err_o` low and `err_code_o` = 8'h00.
- R8: `done_o` and `err_o` are never high together. Both, and `err_code_o`, hold their values until the next accepted start, which clears them.
- R9: A start pulse while `busy_o` is high is ignored. The operation in progress keeps its latched arguments.
- R10: After reset the block is idle: `busy_o`, `done_o`, `err_o` and `mb_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a sector write |
| track_i | input | 8 | Track number |
| sector_i | input | 8 | Zero-based sector number |
| size_i | input | 2 | Payload size code, length = 128 << code |
| base_addr_i | input | 16 | First payload address |
| rx_dir_i | input | 1 | Controller is in receive direction |
| taken_i | input | 1 | Controller has consumed the previous byte |
| mb_wr_o | output | 1 | Mailbox write strobe |
| mb_data_o | output | 8 | Mailbox write byte |
| ack_vld_i | input | 1 | Acknowledge byte is present |
| ack_code_i | input | 8 | Acknowledge value, 8'h00 is success |
| mem_addr_o | output | 16 | Payload read address |
| mem_data_i | input | 8 | Payload read data, same cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation succeeded |
| err_o | output | 1 | Last operation failed |
| err_code_o | output | 8 | Failing acknowledge value or timeout code |

## Verification
Successful runs use all four size codes. They cover a mid-range sector, sector 254 and the wrapping sector 255, and compare the full byte stream, which separates ordering faults, sector-offset faults and length faults. Non-zero acknowledges are injected at the first, the third and the final acknowledge point, so an abort that happens too late, or a wrong copy of the error code, shows up in the byte count. The payload flow is then held off for exactly 254 and 255 polls through `taken_i`, and for a long stretch through `rx_dir_i` alone. These runs pin the timeout boundary to the cycle and show that both status bits gate the strobe. A start during a busy run, and long idle gaps after completion, exercise the hold and ignore behaviour.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_TRK_CMD, S_TRK_ARG, S_TRK_ACK,
    S_SEC_CMD, S_SEC_ARG, S_SEC_ACK,
    S_SEEK_CMD, S_SEEK_ACK, S_WR_CMD, S_WR_ACK,
    S_DATA, S_END_ACK
  } seq_st_e;

  localparam logic [7:0] ACK_OK = 8'h00;
endpackage

// File: rtl/sws_poll_tmr.sv
module sws_poll_tmr #(
  parameter int POLL_MAX = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic poll_i,
  output logic expire_o
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  // counts consecutive failed polls; any non-poll cycle restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (poll_i) cnt_q <= cnt_q + CW'(1);
    else             cnt_q <= '0;
  end

  assign expire_o = poll_i && (cnt_q == CW'(POLL_MAX - 1));
endmodule

// File: rtl/sws_len_ctr.sv
module sws_len_ctr #(
  parameter int ADDR_W  = 16,
  parameter int SIZE_W  = 2,
  parameter int MIN_LEN = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int MAX_LEN = MIN_LEN << ((1 << SIZE_W) - 1);
  localparam int LEN_W   = $clog2(MAX_LEN) + 1;

  logic [LEN_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      rem_q  <= LEN_W'(MIN_LEN) << size_i;
      addr_q <= base_i;
    end else if (step_i) begin
      rem_q  <= rem_q - LEN_W'(1);
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == LEN_W'(1));
endmodule

// File: rtl/sws_fsm.sv
module sws_fsm
  import sws_pkg::*;
#(
  parameter logic [7:0] CMD_TRK  = 8'h21,
  parameter logic [7:0] CMD_SEC  = 8'h22,
  parameter logic [7:0] CMD_SEEK = 8'h23,
  parameter logic [7:0] CMD_WR   = 8'h24,
  parameter logic [7:0] TMO_CODE = 8'hE1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] track_i,
  input  logic [7:0] sector_i,
  input  logic       rdy_i,
  input  logic       last_i,
  input  logic       expire_i,
  input  logic       ack_vld_i,
  input  logic [7:0] ack_code_i,
  input  logic [7:0] mem_data_i,
  output seq_st_e    st_o,
  output logic       mb_wr_o,
  output logic [7:0] mb_data_o,
  output logic       load_o,
  output logic       step_o,
  output logic       poll_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] err_code_o
);
  seq_st_e    st_q, st_d;
  logic [7:0] trk_q, sec_q;
  logic       is_send, is_ack, ack_bad;
  logic [7:0] byte_d;

  always_comb begin
    is_send = 1'b1;
    byte_d  = '0;
    unique case (st_q)
      S_TRK_CMD:  byte_d = CMD_TRK;
      S_TRK_ARG:  byte_d = trk_q;
      S_SEC_CMD:  byte_d = CMD_SEC;
      S_SEC_ARG:  byte_d = sec_q + 8'd1;  // disk numbering starts at one
      S_SEEK_CMD: byte_d = CMD_SEEK;
      S_WR_CMD:   byte_d = CMD_WR;
      S_DATA:     byte_d = mem_data_i;
      default:    is_send = 1'b0;
    endcase
  end

  assign is_ack  = st_q inside {S_TRK_ACK, S_SEC_ACK, S_SEEK_ACK, S_WR_ACK, S_END_ACK};
  assign ack_bad = ack_code_i != ACK_OK;

  assign mb_wr_o   = is_send && rdy_i;
  assign mb_data_o = byte_d;
  assign load_o    = (st_q == S_IDLE) && start_i;
  assign step_o    = (st_q == S_DATA) && rdy_i;
  assign poll_o    = (st_q == S_DATA) && !rdy_i;
  assign busy_o    = st_q != S_IDLE;
  assign st_o      = st_q;

  always_comb begin
    st_d = st_q;
    if (is_ack) begin
      if (ack_vld_i) begin
        if (ack_bad || st_q == S_END_ACK) st_d = S_IDLE;
        else                              st_d = seq_st_e'(st_q + 4'd1);
      end
    end else if (st_q == S_IDLE) begin
      if (start_i) st_d = S_TRK_CMD;
    end else if (st_q == S_DATA) begin
      if (rdy_i && last_i) st_d = S_END_ACK;
      else if (expire_i)   st_d = S_IDLE;
    end else if (rdy_i) begin
      st_d = seq_st_e'(st_q + 4'd1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      trk_q      <= '0;
      sec_q      <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= '0;
    end else begin
      st_q <= st_d;
      if (load_o) begin
        trk_q      <= track_i;
        sec_q      <= sector_i;
        done_o     <= 1'b0;
        err_o      <= 1'b0;
        err_code_o <= '0;
      end else if (is_ack && ack_vld_i) begin
        if (ack_bad) begin
          err_o      <= 1'b1;
          err_code_o <= ack_code_i;
        end else if (st_q == S_END_ACK) begin
          done_o <= 1'b1;
        end
      end else if (expire_i) begin
        err_o      <= 1'b1;
        err_code_o <= TMO_CODE;
      end
    end
  end
endmodule

// File: rtl/sec_wr_seq.sv
module sec_wr_seq
  import sws_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         SIZE_W   = 2,
  parameter int         MIN_LEN  = 128,
  parameter int         POLL_MAX = 255,
  parameter logic [7:0] CMD_TRK  = 8'h21,
  parameter logic [7:0] CMD_SEC  = 8'h22,
  parameter logic [7:0] CMD_SEEK = 8'h23,
  parameter logic [7:0] CMD_WR   = 8'h24,
  parameter logic [7:0] TMO_CODE = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        track_i,
  input  logic [7:0]        sector_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              rx_dir_i,
  input  logic              taken_i,
  output logic              mb_wr_o,
  output logic [7:0]        mb_data_o,
  input  logic              ack_vld_i,
  input  logic [7:0]        ack_code_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        err_code_o
);
  seq_st_e st;
  logic    rdy, last, expire, load, step, poll;

  assign rdy = rx_dir_i && taken_i;

  sws_fsm #(
    .CMD_TRK(CMD_TRK), .CMD_SEC(CMD_SEC), .CMD_SEEK(CMD_SEEK),
    .CMD_WR(CMD_WR), .TMO_CODE(TMO_CODE)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .track_i, .sector_i,
    .rdy_i(rdy), .last_i(last), .expire_i(expire),
    .ack_vld_i, .ack_code_i, .mem_data_i,
    .st_o(st), .mb_wr_o, .mb_data_o,
    .load_o(load), .step_o(step), .poll_o(poll),
    .busy_o, .done_o, .err_o, .err_code_o
  );

  sws_len_ctr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_LEN(MIN_LEN)) u_len (
    .clk_i, .rst_ni, .load_i(load), .size_i, .base_i(base_addr_i),
    .step_i(step), .addr_o(mem_addr_o), .last_o(last)
  );

  sws_poll_tmr #(.POLL_MAX(POLL_MAX)) u_tmr (
    .clk_i, .rst_ni, .poll_i(poll), .expire_o(expire)
  );
endmodule

// File: rtl/sws_chk.sv
module sws_chk
  import sws_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         POLL_MAX = 255,
  parameter logic [7:0] TMO_CODE = 8'hE1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input seq_st_e           st,
  input logic              start_i,
  input logic              rx_dir_i,
  input logic              taken_i,
  input logic              mb_wr_o,
  input logic              ack_vld_i,
  input logic [7:0]        ack_code_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [7:0]        err_code_o
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic          wait_data, in_ack;
  logic [CW-1:0] fails_q;

  assign wait_data = (st == S_DATA) && !(rx_dir_i && taken_i);
  assign in_ack    = st inside {S_TRK_ACK, S_SEC_ACK, S_SEEK_ACK, S_WR_ACK, S_END_ACK};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fails_q <= '0;
    else if (wait_data) fails_q <= fails_q + CW'(1);
    else                fails_q <= '0;
  end

  a_r4_wr_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_wr_o |-> (rx_dir_i && taken_i));

  a_r5_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_data && fails_q == CW'(POLL_MAX - 1)) |=> (err_o && err_code_o == TMO_CODE && !busy_o));

  a_r6_ack_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ack && ack_vld_i && ack_code_i != ACK_OK) |=> (err_o && !busy_o && err_code_o == $past(ack_code_i)));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_DATA && mb_wr_o) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r8_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> (err_o && $stable(err_code_o)));

  a_r9_busy_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_o && !err_o));
endmodule

bind sec_wr_seq sws_chk #(.ADDR_W(ADDR_W), .POLL_MAX(POLL_MAX), .TMO_CODE(TMO_CODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st(st), .start_i(start_i),
  .rx_dir_i(rx_dir_i), .taken_i(taken_i), .mb_wr_o(mb_wr_o),
  .ack_vld_i(ack_vld_i), .ack_code_i(ack_code_i), .mem_addr_o(mem_addr_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/sim_sec_wr_seq.sv
`timescale 1ns/1ps
module sim_sec_wr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  track_i = '0, sector_i = '0;
  logic [1:0]  size_i = '0;
  logic [15:0] base_addr_i = '0;
  logic        rx_dir_i = 1'b1, taken_i = 1'b1;
  logic        mb_wr_o;
  logic [7:0]  mb_data_o;
  logic        ack_vld_i = 1'b0;
  logic [7:0]  ack_code_i = '0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_i;
  logic        busy_o, done_o, err_o;
  logic [7:0]  err_code_o;

  always #2 clk_i = ~clk_i;

  sec_wr_seq u0 (.*);

  // bench-side payload memory
  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign mem_data_i = mem_val(mem_addr_o);

  int nchk = 0, nfail = 0, cyc = 0;

  // controller model state and per-test configuration
  logic [7:0] log_b [0:1100];
  logic [7:0] codes [0:4];
  int nw, nack, hold, dhold, ack_cd, viol;
  int exp_len, hold_idx, hold_val, dir_idx, dir_val;
  logic mdl_clr = 1'b0;

  always @(negedge clk_i) begin
    if (mdl_clr) begin
      nw = 0; nack = 0; hold = 0; dhold = 0; ack_cd = 0; viol = 0;
      ack_vld_i = 1'b0; taken_i = 1'b1; rx_dir_i = 1'b1;
    end else begin
      ack_vld_i = 1'b0;
      if (ack_cd > 0) begin
        ack_cd--;
        if (ack_cd == 0) begin
          ack_vld_i = 1'b1; ack_code_i = codes[nack]; nack++;
        end
      end
      if (hold > 0) hold--;
      if (dhold > 0) dhold--;
      if (mb_wr_o) begin
        if (!(rx_dir_i && taken_i)) viol++;
        if (nw <= 1100) log_b[nw] = mb_data_o;
        nw++;
        if (nw == 2 || nw == 4 || nw == 5 || nw == 6 || nw == 6 + exp_len) ack_cd = 3;
        hold  = (nw == hold_idx) ? hold_val : 1;
        dhold = (nw == dir_idx) ? dir_val : 0;
      end
      taken_i  = (hold == 0);
      rx_dir_i = (dhold == 0);
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc >= 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic setup(input logic [1:0] sz, input int hi, input int hv, input int di, input int dv);
    exp_len = 128 << sz; hold_idx = hi; hold_val = hv; dir_idx = di; dir_val = dv;
    for (int i = 0; i < 5; i++) codes[i] = 8'h00;
    tick(1); mdl_clr = 1'b1; tick(1); mdl_clr = 1'b0;
  endtask

  task automatic launch(input logic [7:0] trk, input logic [7:0] sec, input logic [1:0] sz,
                        input logic [15:0] base);
    track_i = trk; sector_i = sec; size_i = sz; base_addr_i = base;
    start_i = 1'b1; tick(1); start_i = 1'b0;
  endtask

  task automatic wait_end();
    while (!(done_o || err_o)) tick(1);
    tick(6);
  endtask

  task automatic check_stream(input string tag, input logic [7:0] trk, input logic [7:0] sec,
                              input logic [1:0] sz, input logic [15:0] base);
    int bad = 0;
    int len = 128 << sz;
    // R1 order, R2 sector offset, R3 payload content and length
    if (log_b[0] != 8'h21 || log_b[1] != trk || log_b[2] != 8'h22 ||
        log_b[4] != 8'h23 || log_b[5] != 8'h24) bad++;
    chk(bad == 0, {tag, " R1 command order"}, bad, 0);
    chk(log_b[3] == sec + 8'd1, {tag, " R2 sector arg"}, log_b[3], sec + 8'd1);
    bad = 0;
    for (int j = 0; j < len; j++) if (log_b[6+j] != mem_val(base + 16'(j))) bad++;
    chk(bad == 0 && nw == 6 + len, {tag, " R3 payload"}, nw, 6 + len);
    chk(done_o && !err_o && err_code_o == 8'h00, {tag, " R7 done"}, {done_o, err_o}, 2);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !err_o && !mb_wr_o, "R10 reset idle",
        {busy_o, done_o, err_o, mb_wr_o}, 0);
  endtask

  task automatic t_ok(input logic [7:0] trk, input logic [7:0] sec, input logic [1:0] sz,
                      input logic [15:0] base);
    setup(sz, 0, 0, 0, 0);
    launch(trk, sec, sz, base);
    wait_end();
    check_stream("ok", trk, sec, sz, base);
  endtask

  task automatic t_hold();
    tick(20);
    chk(done_o && !err_o, "R8 done held", done_o, 1);
    setup(0, 0, 0, 0, 0);
    codes[0] = 8'h55;
    launch(8'h10, 8'h03, 0, 16'h0);
    chk(busy_o && !done_o, "R8 start clears done", done_o, 0);
    wait_end();
    chk(err_o && err_code_o == 8'h55 && nw == 2, "R6 abort at track ack", nw, 2);
    tick(20);
    chk(err_o && !done_o && err_code_o == 8'h55, "R8 error held", err_code_o, 8'h55);
  endtask

  task automatic t_ack_err(input int step, input logic [7:0] code, input int exp_nw);
    setup(0, 0, 0, 0, 0);
    codes[step] = code;
    launch(8'h40, 8'h07, 0, 16'h0300);
    wait_end();
    chk(err_o && !done_o && err_code_o == code, "R6 error code", err_code_o, code);
    chk(nw == exp_nw, "R6 no bytes after bad ack", nw, exp_nw);
  endtask

  task automatic t_poll(input int d, input logic expect_ok);
    setup(1, 9, d, 0, 0);
    launch(8'h02, 8'h01, 1, 16'h2000);
    wait_end();
    if (expect_ok) begin
      check_stream("poll254", 8'h02, 8'h01, 1, 16'h2000);
      chk(viol == 0, "R5 254 failed polls tolerated", viol, 0);
    end else begin
      chk(err_o && err_code_o == 8'hE1, "R5 timeout code", err_code_o, 8'hE1);
      chk(nw == 9, "R5 stop after timeout", nw, 9);
    end
  endtask

  task automatic t_dir(input int dv, input logic expect_ok);
    setup(0, 0, 0, 8, dv);
    launch(8'h11, 8'h22, 0, 16'h0080);
    wait_end();
    if (expect_ok) begin
      check_stream("dir", 8'h11, 8'h22, 0, 16'h0080);
      chk(viol == 0, "R4 no write while direction low", viol, 0);
    end else begin
      chk(err_o && err_code_o == 8'hE1 && nw == 8, "R4 direction alone blocks write", nw, 8);
    end
  endtask

  task automatic t_busy_start();
    setup(0, 0, 0, 0, 0);
    launch(8'h33, 8'h04, 0, 16'h0500);
    tick(3);
    launch(8'h77, 8'h09, 2, 16'h0900);
    wait_end();
    chk(log_b[1] == 8'h33 && log_b[3] == 8'h05, "R9 start ignored while busy", log_b[1], 8'h33);
    chk(nw == 6 + 128 && done_o, "R9 length unchanged", nw, 134);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_ok(8'h05, 8'h00, 0, 16'h1000);
    t_ok(8'h4C, 8'hFE, 1, 16'h00F0);
    t_ok(8'h00, 8'h1A, 2, 16'hFF80);
    t_ok(8'hFF, 8'hFF, 3, 16'h4000);
    t_hold();
    t_ack_err(2, 8'h07, 5);
    t_ack_err(4, 8'h9A, 6 + 128);
    t_poll(254, 1'b1);
    t_poll(255, 1'b0);
    t_dir(40, 1'b1);
    t_dir(300, 1'b0);
    t_busy_start();
    summary();
  end
endmodule